// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block sits on the controller side of a two-wire serial bus. Its job is to bring every attached slave back to a known idle state after a transfer was cut short by a power loss, a system reset or an aborted transaction. It drives the clock and data lines only through active-high "pull low" enables. When an enable is off, the line is released and the external pull-up holds it high.

A single-cycle request starts a fixed pattern on the bus:

1. A start condition.
2. Nine free clock pulses with the data line released. These let a slave that is stuck mid-byte, or in its acknowledge slot, shift out and let go of the data line.
3. A repeated start condition.
4. A stop condition.

After the stop, the block pulses `done` for one cycle. Every bus phase lasts a programmable number of system clocks. That count is captured when the request is accepted.

Top module: `bus_recover_seq`

## Requirements
- R1: After reset and while idle, `scl_oe`, `sda_oe`, `busy` and `done` are all 0. Both lines are released.
- R2: The bus setup and start edge are timed as follows:
  - For the first half-period after acceptance, both lines stay released.
  - At the start of the second half-period, `sda_oe` rises while `scl_oe` stays 0. This is a start condition: SDA falls while SCL is high.
- R3: After the start, SCL is pulled low and then SDA is released. Nine low/high clock pulses follow with `sda_oe`=0. A tenth SCL high follows; it is the setup of the repeated start.
- R4: The sequence ends in two edges, both while SCL stays high:
  - SDA falls, forming the repeated start.
  - One half-period later, SDA rises, forming the stop.
  - Across the whole sequence this gives exactly two start conditions and one stop condition.
- R5: SDA changes while SCL is high only at the three start/stop edges. SCL and SDA never change in the same cycle.
- R6: Each phase lasts H system clocks, where H = `half_period` (0 is treated as 1). The sequence has 25 phases, so `busy` is high for exactly 25*H cycles.
- R7: `busy` rises in the cycle after the request is accepted. `done` is high for exactly one cycle, the first cycle in which `busy` is low again.
- R8: A request arriving while `busy` is high is ignored. It neither restarts nor lengthens the sequence.
- R9: A synchronous reset during a sequence returns the block to idle in the next cycle, with both lines released.
- R10: `half_period` is sampled only when a request is accepted. Changing it during a sequence has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Single-cycle recovery request |
| half_period | input | DIV_W | System clocks per bus phase (0 acts as 1) |
| scl_oe | output | 1 | 1 = pull SCL low |
| sda_oe | output | 1 | 1 = pull SDA low |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The conditions that are hardest to reach from the ports are the ones that happen mid-sequence:
- a second request arriving while the sequence runs;
- `half_period` changing after the request has been accepted;
- a reset landing in the middle of the dummy clocks.

The bench counts the busy cycles after acceptance. At a chosen phase index it injects the extra request or the new divider value, then checks that the length and the line pattern are unchanged. It also follows the released line levels cycle by cycle. From them it picks out each SDA edge that occurs while SCL is high, and checks that the start and stop edges land at the expected phase boundaries.

// File: rtl/brs_pkg.sv
package brs_pkg;

  localparam int unsigned DUMMY_CLOCKS = 9;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETUP,   // both released, bus setup
    ST_START,   // SDA low, SCL high: start
    ST_LOCK,    // SCL low, SDA still low
    ST_CLO,     // dummy clock low, SDA released
    ST_CHI,     // dummy clock high, SDA released
    ST_RLO,     // SCL low before repeated start
    ST_RHI,     // SCL high, SDA high: repeated start setup
    ST_RSTART,  // SDA low, SCL high: repeated start
    ST_STOP     // SDA released, SCL high: stop
  } brs_state_e;

  typedef struct packed {
    logic scl_low;
    logic sda_low;
  } brs_drive_t;

  function automatic brs_drive_t drive_of(input brs_state_e s);
    brs_drive_t d;
    case (s)
      ST_START:  d = '{scl_low: 1'b0, sda_low: 1'b1};
      ST_LOCK:   d = '{scl_low: 1'b1, sda_low: 1'b1};
      ST_CLO:    d = '{scl_low: 1'b1, sda_low: 1'b0};
      ST_RLO:    d = '{scl_low: 1'b1, sda_low: 1'b0};
      ST_RSTART: d = '{scl_low: 1'b0, sda_low: 1'b1};
      default:   d = '{scl_low: 1'b0, sda_low: 1'b0};
    endcase
    return d;
  endfunction

endpackage

// File: rtl/brs_tick.sv
module brs_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             run,
  input  logic [DIV_W-1:0] hp_in,
  output logic             tick
);

  function automatic logic [DIV_W-1:0] clamp_half(input logic [DIV_W-1:0] v);
    return (v == '0) ? DIV_W'(1) : v;
  endfunction

  logic [DIV_W-1:0] span;
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      span <= DIV_W'(1);
      cnt  <= DIV_W'(1);
    end else if (load) begin
      span <= clamp_half(hp_in);
      cnt  <= DIV_W'(1);
    end else if (run) begin
      if (tick) cnt <= DIV_W'(1);
      else      cnt <= cnt + DIV_W'(1);
    end
  end

  assign tick = run && (cnt == span);

  AST_SPAN_NONZERO: assert property (@(posedge clk) disable iff (rst)
    span != '0);  // R6
  AST_CNT_IN_SPAN: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt >= DIV_W'(1)) && (cnt <= span));  // R6
  AST_SPAN_HELD: assert property (@(posedge clk) disable iff (rst)
    (run && !load) |=> $stable(span));  // R10

endmodule

// File: rtl/brs_fsm.sv
module brs_fsm
  import brs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic tick,
  output logic accept,
  output logic busy,
  output logic done,
  output logic scl_oe,
  output logic sda_oe
);

  localparam int BIT_W = $clog2(DUMMY_CLOCKS + 1);

  brs_state_e       state, nstate;
  logic [BIT_W-1:0] nbits;
  brs_drive_t       drv;

  // named events for the assertions
  logic last_dummy;
  logic at_bus_mark;

  assign accept      = req && (state == ST_IDLE);
  assign last_dummy  = (state == ST_CHI) && (nbits == BIT_W'(DUMMY_CLOCKS - 1));
  assign at_bus_mark = (state == ST_START) || (state == ST_RSTART) || (state == ST_STOP);

  always_comb begin
    nstate = state;
    case (state)
      ST_IDLE:   if (accept) nstate = ST_SETUP;
      ST_SETUP:  if (tick) nstate = ST_START;
      ST_START:  if (tick) nstate = ST_LOCK;
      ST_LOCK:   if (tick) nstate = ST_CLO;
      ST_CLO:    if (tick) nstate = ST_CHI;
      ST_CHI:    if (tick) nstate = last_dummy ? ST_RLO : ST_CLO;
      ST_RLO:    if (tick) nstate = ST_RHI;
      ST_RHI:    if (tick) nstate = ST_RSTART;
      ST_RSTART: if (tick) nstate = ST_STOP;
      ST_STOP:   if (tick) nstate = ST_IDLE;
      default:   nstate = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      nbits <= '0;
      done  <= 1'b0;
    end else begin
      state <= nstate;
      done  <= (state == ST_STOP) && tick;
      if (accept)
        nbits <= '0;
      else if ((state == ST_CHI) && tick)
        nbits <= nbits + BIT_W'(1);
    end
  end

  assign drv    = drive_of(state);
  assign scl_oe = drv.scl_low;
  assign sda_oe = drv.sda_low;
  assign busy   = (state != ST_IDLE);

  AST_DUMMY_BOUND: assert property (@(posedge clk) disable iff (rst)
    nbits <= BIT_W'(DUMMY_CLOCKS));  // R3
  AST_DUMMY_SDA_FREE: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_CLO) || (state == ST_CHI)) |-> !sda_oe);  // R3
  AST_SDA_HIGH_SCL_MARK: assert property (@(posedge clk) disable iff (rst)
    (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe))) |-> at_bus_mark);  // R5
  AST_NO_JOINT_EDGE: assert property (@(posedge clk) disable iff (rst)
    (scl_oe != $past(scl_oe)) |-> (sda_oe == $past(sda_oe)));  // R5

endmodule

// File: rtl/bus_recover_seq.sv
module bus_recover_seq #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_req,
  input  logic [DIV_W-1:0] half_period,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             busy,
  output logic             done
);

  logic accept;
  logic tick;

  brs_fsm u_fsm (
    .clk    (clk),
    .rst    (rst),
    .req    (start_req),
    .tick   (tick),
    .accept (accept),
    .busy   (busy),
    .done   (done),
    .scl_oe (scl_oe),
    .sda_oe (sda_oe)
  );

  brs_tick #(.DIV_W(DIV_W)) u_tick (
    .clk   (clk),
    .rst   (rst),
    .load  (accept),
    .run   (busy),
    .hp_in (half_period),
    .tick  (tick)
  );

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!scl_oe && !sda_oe));  // R1
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);  // R7
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy) && !busy));  // R7
  AST_BUSY_IGNORES_REQ: assert property (@(posedge clk) disable iff (rst)
    (busy && start_req) |-> !accept);  // R8

endmodule

// File: tb/bus_recover_seq_test.sv
module bus_recover_seq_test;

  localparam int DIV_W = 8;
  localparam int NV = 4;
  localparam int VHP  [0:NV-1] = '{1, 2, 0, 5};
  localparam int VLEN [0:NV-1] = '{25, 50, 25, 125};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_req = 1'b0;
  logic [DIV_W-1:0] half_period = '0;
  logic scl_oe, sda_oe, busy, done;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  always #5 clk = ~clk;

  bus_recover_seq #(.DIV_W(DIV_W)) uut (
    .clk(clk), .rst(rst), .start_req(start_req), .half_period(half_period),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // expected {scl_oe, sda_oe} for phase index ph
  function automatic int exp_drive(input int ph);
    if (ph == 0) return 0;
    if (ph == 1) return 1;
    if (ph == 2) return 3;
    if (ph >= 3 && ph <= 20) return ((ph - 3) % 2 == 0) ? 2 : 0;
    if (ph == 21) return 2;
    if (ph == 23) return 1;
    return 0;
  endfunction

  task automatic run_seq(input int hp, input int exp_len, input int hp_mid, input bit poke);
    int h = (hp == 0) ? 1 : hp;
    int k = 0;
    int mism = 0, starts = 0, stops = 0, rises = 0, joint = 0;
    int first_start = -1, last_stop = -1;
    bit p_scl = 1'b1, p_sda = 1'b1, seen_done = 1'b0, stuck = 1'b0;
    bit scl_l, sda_l;
    @(negedge clk);
    half_period = DIV_W'(hp);
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    chk(busy === 1'b1, "R7", "busy after accept", int'(busy), 1);
    while (!seen_done && !stuck && k < 5000) begin
      if (busy) begin
        if (int'({scl_oe, sda_oe}) != exp_drive(k / h)) mism++;
        scl_l = !scl_oe;
        sda_l = !sda_oe;
        if (scl_l != p_scl && sda_l != p_sda) joint++;
        if (scl_l && p_scl && sda_l != p_sda) begin
          if (!sda_l) begin
            starts++;
            if (first_start < 0) first_start = k;
          end else begin
            stops++;
            last_stop = k;
          end
        end
        if (scl_l && !p_scl && starts == 1) rises++;
        p_scl = scl_l;
        p_sda = sda_l;
        if (hp_mid >= 0 && k == 2) half_period = DIV_W'(hp_mid);
        start_req = (poke && (k == 3 || k == 4));
        k++;
        @(negedge clk);
      end else if (done) begin
        seen_done = 1'b1;
      end else begin
        stuck = 1'b1;
      end
    end
    start_req = 1'b0;
    chk(seen_done, "R7", "done after busy", int'(seen_done), 1);
    chk(k == exp_len, (hp_mid >= 0) ? "R10" : "R6", "busy length", k, exp_len);
    chk(mism == 0, "R3", "line pattern mismatches", mism, 0);
    chk(first_start == h, "R2", "start edge cycle", first_start, h);
    chk(starts == 2, "R4", "start conditions", starts, 2);
    chk(stops == 1 && last_stop == 24 * h, "R4", "stop edge cycle", last_stop, 24 * h);
    chk(rises == 10, "R3", "SCL rises between starts", rises, 10);
    chk(joint == 0, "R5", "joint SCL/SDA changes", joint, 0);
    chk(!scl_oe && !sda_oe, "R1", "lines released at done", int'({scl_oe, sda_oe}), 0);
    @(negedge clk);
    chk(done === 1'b0, "R7", "done width", int'(done), 0);
    chk(busy === 1'b0, poke ? "R8" : "R7", "idle after done", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({scl_oe, sda_oe, busy, done} === 4'b0000, "R1", "reset outputs",
        int'({scl_oe, sda_oe, busy, done}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk({scl_oe, sda_oe, busy, done} === 4'b0000, "R1", "idle outputs",
        int'({scl_oe, sda_oe, busy, done}), 0);

    for (int i = 0; i < NV; i++) run_seq(VHP[i], VLEN[i], -1, 1'b0);

    // R8 and R10: extra requests and a new divider value mid-sequence
    run_seq(3, 75, 7, 1'b1);

    // R9: reset during the dummy clocks
    @(negedge clk);
    half_period = DIV_W'(2);
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    repeat (12) @(negedge clk);
    chk(busy === 1'b1, "R9", "busy before reset", int'(busy), 1);
    rst = 1'b1;
    @(negedge clk);
    chk({scl_oe, sda_oe, busy, done} === 4'b0000, "R9", "outputs after mid reset",
        int'({scl_oe, sda_oe, busy, done}), 0);
    rst = 1'b0;
    run_seq(1, 25, -1, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule